// File: doc/BRIEF.md
# Writeback-Aware Set Replacement Unit

This unit chooses victims and places new lines for one set of a 16-way last-level cache. Its goal is to avoid writebacks. It keeps a recency stack of way indices, with position 0 as the most recently used, and one dirty bit per way. A threshold `x` splits the stack in two. Positions 0 to x-1 form a protected region of frequently hit lines. Positions x to 15 form an exposed region. A miss evicts a clean line from the exposed region. The new line goes to position x, the top of the exposed region, and not to position 0. Dirty lines stay in the cache until no clean choice is left.

The surrounding cache controller does the tag lookup and presents each access with a hit flag, a write flag and, on a hit, the matching way. One cycle later the unit answers. The answer gives the way that was touched or replaced, whether that line was dirty and whether it must be written back. Software or an epoch-based policy selector can change the threshold. The unit picks up a new value only in cycles with no request.

Top module: `wb_repl_set`

## Requirements
- R1: After reset, way i is at stack position i, so way 15 is the LRU line. All dirty bits are clear, the working threshold is 0 and `resp_valid` is low.
- R2: A request accepted on a clock edge is answered after that edge: `resp_valid` is high for exactly one cycle, and `resp_miss` equals the inverse of the request's hit flag.
- R3: A hit moves the accessed way to position 0. The ways that were above its old position each move down one place. The rest of the stack is unchanged.
- R4: A write hit sets the accessed way's dirty bit. A read hit leaves the dirty bit as it was.
- R5: On a miss, the victim is the clean way at the highest-numbered position within positions x to 15.
- R6: If positions x to 15 hold no clean way, the way at position 15 is evicted, and `victim_dirty` and `wb_needed` both read 1.
- R7: The victim way is refilled at position x. The ways that were from x up to its old position each move down one place. Its dirty bit becomes 1 after a write miss and 0 after a read miss.
- R8: The working threshold copies the `thresh` input only on edges where `req_valid` is low. While requests arrive back to back, changes on `thresh` have no effect.
- R9: A hit response reports the accessed way on `victim_way`, with `victim_dirty` and `wb_needed` both 0.
- R10: Threshold 0 makes the whole stack exposed, so fills go to position 0. Threshold 15 exposes only position 15, so fills go to position 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | Tag lookup hit |
| req_write | input | 1 | Access is a store |
| req_way | input | 4 | Way that matched (used on hits) |
| thresh | input | 4 | Size of the protected region, 0 to 15 |
| resp_valid | output | 1 | Response present |
| resp_miss | output | 1 | Response belongs to a miss |
| victim_way | output | 4 | Replaced way on a miss, touched way on a hit |
| victim_dirty | output | 1 | Replaced line was dirty |
| wb_needed | output | 1 | Replaced line must be written back |

## Verification
Directed sequences target specific behaviours:
- Hit chains to ways deep in the stack separate a true move-to-front from a swap.
- Write hits that fill the exposed region with dirty lines force the LRU fallback and its writeback flag.
- Write misses followed by repeated read misses show the dirty state a fill leaves behind.
- The extreme thresholds 0 and 15 separate insertion at the top of the stack from insertion at the bottom.

A burst of back-to-back requests with a changing `thresh` input shows whether the threshold is sampled mid-burst. A long random mix of hits, misses, reads and writes, with occasional idle cycles that reload the threshold, is compared on every clock against a behavioural model of the stack.

// File: rtl/wb_repl_set.sv
module wb_repl_set #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_hit,
  input  logic          req_write,
  input  logic [WW-1:0] req_way,
  input  logic [WW-1:0] thresh,
  output logic          resp_valid,
  output logic          resp_miss,
  output logic [WW-1:0] victim_way,
  output logic          victim_dirty,
  output logic          wb_needed
);

  logic [WW-1:0] stk [WAYS];
  logic [WW-1:0] nxt [WAYS];
  logic [WAYS-1:0] dirty;
  logic [WW-1:0] thr_q;

  logic [WW-1:0] hit_pos, vic_pos, src_pos, dst_pos, mov_way;
  logic          vic_d;

  always_comb begin
    hit_pos = '0;
    vic_pos = WW'(WAYS - 1);
    for (int p = 0; p < WAYS; p++) begin
      if (stk[p] == req_way) hit_pos = WW'(p);
      if (p >= int'(thr_q) && !dirty[stk[p]]) vic_pos = WW'(p);
    end
  end

  assign src_pos = req_hit ? hit_pos : vic_pos;
  assign dst_pos = req_hit ? '0 : thr_q;
  assign mov_way = stk[src_pos];
  assign vic_d   = dirty[mov_way];

  always_comb begin
    nxt = stk;
    for (int p = 1; p < WAYS; p++)
      if (p > int'(dst_pos) && p <= int'(src_pos)) nxt[p] = stk[p-1];
    nxt[dst_pos] = mov_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < WAYS; p++) stk[p] <= WW'(p);
      dirty        <= '0;
      thr_q        <= '0;
      resp_valid   <= 1'b0;
      resp_miss    <= 1'b0;
      victim_way   <= '0;
      victim_dirty <= 1'b0;
      wb_needed    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      if (!req_valid) begin
        thr_q        <= thresh;
        resp_miss    <= 1'b0;
        victim_way   <= '0;
        victim_dirty <= 1'b0;
        wb_needed    <= 1'b0;
      end else begin
        stk <= nxt;
        if (req_hit) begin
          if (req_write) dirty[req_way] <= 1'b1;
          resp_miss    <= 1'b0;
          victim_way   <= req_way;
          victim_dirty <= 1'b0;
          wb_needed    <= 1'b0;
        end else begin
          dirty[mov_way] <= req_write;
          resp_miss      <= 1'b1;
          victim_way     <= mov_way;
          victim_dirty   <= vic_d;
          wb_needed      <= vic_d;
        end
      end
    end
  end

endmodule

// File: rtl/wb_repl_set_chk.sv
module wb_repl_set_chk #(
  parameter int WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_hit,
  input logic [WW-1:0] thr_q,
  input logic          resp_valid,
  input logic          resp_miss,
  input logic          victim_dirty,
  input logic          wb_needed
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  a_r2_miss_kind: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (resp_miss == !$past(req_hit)));

  a_r8_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $stable(thr_q));

  a_r9_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_miss) |-> (!victim_dirty && !wb_needed));

  a_r6_wb_dirty_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wb_needed |-> (resp_valid && resp_miss && victim_dirty));

endmodule

bind wb_repl_set wb_repl_set_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
  .thr_q(thr_q), .resp_valid(resp_valid), .resp_miss(resp_miss),
  .victim_dirty(victim_dirty), .wb_needed(wb_needed)
);

// File: tb/tb_wb_repl_set.sv
module tb_wb_repl_set;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, req_valid, req_hit, req_write;
  logic [3:0] req_way, thresh;
  logic       resp_valid, resp_miss, victim_dirty, wb_needed;
  logic [3:0] victim_way;

  wb_repl_set dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_write(req_write), .req_way(req_way), .thresh(thresh),
    .resp_valid(resp_valid), .resp_miss(resp_miss), .victim_way(victim_way),
    .victim_dirty(victim_dirty), .wb_needed(wb_needed)
  );

  int stk_m[16];
  bit d_m[16];
  int thr_m;
  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic move(int src, int dst);
    int m = stk_m[src];
    for (int p = src; p > dst; p--) stk_m[p] = stk_m[p-1];
    stk_m[dst] = m;
  endtask

  task automatic step(string tag, bit v, bit h, bit w, int way, int th);
    int e_way = 0, e_d = 0;
    req_valid = v; req_hit = h; req_write = w;
    req_way = 4'(way); thresh = 4'(th);
    if (v) begin
      if (h) begin
        int hp = 0;
        for (int p = 0; p < 16; p++) if (stk_m[p] == way) hp = p;
        move(hp, 0);
        if (w) d_m[way] = 1'b1;
        e_way = way;
      end else begin
        int vp = 15;
        for (int p = thr_m; p < 16; p++) if (!d_m[stk_m[p]]) vp = p;
        e_way = stk_m[vp];
        e_d = d_m[e_way];
        move(vp, thr_m);
        d_m[e_way] = w;
      end
    end else thr_m = th;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "resp_valid", int'(resp_valid), int'(v));
    if (v) begin
      chk(tag, "resp_miss", int'(resp_miss), int'(!h));
      chk(tag, "victim_way", int'(victim_way), e_way);
      chk(tag, "victim_dirty", int'(victim_dirty), e_d);
      chk(tag, "wb_needed", int'(wb_needed), e_d);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 16; p++) begin stk_m[p] = p; d_m[p] = 1'b0; end
    thr_m = 0;
    rst_n = 1'b0; req_valid = 0; req_hit = 0; req_write = 0; req_way = 0; thresh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "resp_valid after reset", int'(resp_valid), 0);
    // R1: reset stack and threshold 0 -> first two read misses take ways 15 then 14
    step("R1", 1, 0, 0, 0, 9);
    step("R1", 1, 0, 0, 0, 9);
    // R3 / R9: hits deep in the stack, then misses that reveal the new order
    step("R3", 0, 0, 0, 0, 4);
    step("R9", 1, 1, 0, 3, 4);
    step("R9", 1, 1, 0, 12, 4);
    step("R3", 1, 0, 0, 0, 4);
    step("R3", 1, 0, 0, 0, 4);
    // R4 / R6: write-hit every way, then a miss must fall back to LRU with writeback
    step("R4", 0, 0, 0, 0, 12);
    for (int i = 0; i < 16; i++) step("R4", 1, 1, 1, i, 12);
    step("R6", 1, 0, 0, 0, 12);
    step("R6", 1, 0, 0, 0, 12);
    // R4: read hit must not clear dirty; R5: clean line chosen nearest LRU
    step("R4", 1, 1, 0, 7, 12);
    step("R5", 0, 0, 0, 0, 8);
    step("R5", 1, 0, 0, 0, 8);
    step("R5", 1, 0, 0, 0, 8);
    step("R5", 1, 0, 0, 0, 8);
    // R7: write misses leave dirty fills at position x
    step("R7", 1, 0, 1, 0, 8);
    step("R7", 1, 0, 1, 0, 8);
    for (int i = 0; i < 10; i++) step("R7", 1, 0, 0, 0, 8);
    // R8: threshold changes during a back-to-back burst are ignored
    for (int i = 0; i < 8; i++) step("R8", 1, i[0], 0, i, 15 - i);
    step("R8", 0, 0, 0, 0, 2);
    step("R8", 1, 0, 0, 0, 2);
    // R10: extreme thresholds
    step("R10", 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R10", 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 15);
    for (int i = 0; i < 4; i++) step("R10", 1, 0, i[0], 0, 15);
    // random mix compared on every clock
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      int th = (i % 97 == 0) ? int'($urandom_range(0, 15)) : int'(thresh);
      step("R5", r < 85, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           int'($urandom_range(0, 15)), th);
    end
    finish_run();
  end
endmodule